// File: doc/BRIEF.md
# Byte-Serial Accumulator Instruction Sequencer

This block is a multi-cycle control unit. It pulls each instruction from a byte-wide synchronous memory one byte per clock, decodes it, and updates a small register set: a 16-bit program counter, accumulators A and B, and four condition flags. The memory returns read data one cycle after the address is presented. The only write the block makes is a single-cycle store of A.

The supported subset covers four kinds of instruction:
- register-only operations on A;
- operations with an immediate operand byte;
- loads and stores through a one-byte direct address or a two-byte extended address (high byte first);
- a short unconditional branch and a long branch on zero.

Branch targets are measured from the address that follows the whole branch instruction. A halt opcode stops the unit and raises `done`, and so does any opcode outside the subset. Accumulator B is never written by the subset; it takes a parameterised value at reset and is used only as the second operand of the A+B add.

The state machine has eight states:
- FETCH puts PC on the bus, advances PC and goes to OPCODE.
- OPCODE decodes the returned byte. Register-only work goes back to FETCH, halt or an unknown byte goes to HALT, and everything else takes one more byte and goes to BYTE1.
- BYTE1 finishes immediate and short-branch work (to FETCH). It latches a direct address (to MEMACC), or takes another byte (to BYTE2) for extended and long-branch forms. After the prefix byte it either adds B (to FETCH), moves to BYTE2 for a long branch, or goes to HALT.
- BYTE2 forms the extended address (to MEMACC) or latches the high offset byte (to BYTE3).
- BYTE3 resolves the long branch (to FETCH).
- MEMACC drives the effective address and writes on a store (to FETCH) or goes to LOADWAIT on a load.
- LOADWAIT writes the returned byte into A (to FETCH).
- HALT holds.

Top module: `accseq`

## Requirements
- R1: While reset is asserted: PC equals START_PC (default 0x0800), A is 0x00, the flag vector `out_ccr` = {N,Z,V,C} (bit 3 down to bit 0) is 0, `done` is 0 and `mem_we` is 0.
- R2: Extended load 0xB6 hh ll and extended store 0x7A hh ll use address {hh,ll}. The program B6 09 13, 40, 7A 09 14 placed at 0x0800, with 0x6C at 0x0913, writes 0x94 to 0x0914 and leaves the following opcode fetched from 0x0807.
- R3: 0x86 nn loads A with nn. 0x8B nn adds nn to A: C is the carry out of bit 7; V is set when both operands have the same sign and the sum's sign differs; N is bit 7 of the result; Z is set when the result is zero.
- R4: 0x96 nn loads A from address 0x00nn.
- R5: 0x40 replaces A by its two's complement. V is set only when A was 0x80, C is set when the result is non-zero, and N and Z follow the result.
- R6: 0x87 clears A and sets the flags to {0,1,0,0}. 0x47 shifts A right and keeps bit 7; C takes the old bit 0 and V = N xor C. 0x97 leaves A unchanged, sets N and Z from A, and clears V and C.
- R7: The two-byte opcode 0x18 0x06 adds B to A, with flags as in R3.
- R8: 0x20 oo sets PC to (opcode address + 2) + sign-extended oo, forward or backward.
- R9: 0x18 0x27 hh ll sets PC to (opcode address + 4) + {hh,ll} when Z is 1, and to opcode address + 4 when Z is 0.
- R10: Opcode 0x3F halts. `done` rises and stays high, PC stays one past the halt opcode, and no further write occurs.
- R11: An opcode outside the subset halts exactly as in R10 without changing A. So does a byte other than 0x06 or 0x27 after the 0x18 prefix.
- R12: Loads and stores set N and Z from the byte moved and clear V, and they leave C unchanged.
- R13: `mem_we` is high for exactly one cycle per store, with `mem_addr` equal to the effective address and `mem_wdata` equal to A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Store strobe |
| done | output | 1 | High once halted |
| out_pc | output | 16 | Program counter |
| out_a | output | 8 | Accumulator A |
| out_ccr | output | 4 | Flags {N,Z,V,C} |

## Verification
The long branch on zero is the hardest state to reach: its outcome depends on Z left behind by an earlier instruction, and the four-byte form passes through BYTE1, BYTE2 and BYTE3 with PC moving at each step. The bench builds short programs in which a clear or a non-zero immediate load sets Z just before the branch. It places distinct marker loads at both the taken target and the fall-through address, so the final A and the halted PC show which path ran. The backward short branch is handled the same way: the program jumps past a halt and then jumps back onto it.

// File: rtl/accseq_pkg.sv
package accseq_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam int FW = 4;

    localparam int FL_N = 3;
    localparam int FL_Z = 2;
    localparam int FL_V = 1;
    localparam int FL_C = 0;

    localparam logic [DW-1:0] OP_NEG  = 8'h40;
    localparam logic [DW-1:0] OP_CLR  = 8'h87;
    localparam logic [DW-1:0] OP_ASR  = 8'h47;
    localparam logic [DW-1:0] OP_TST  = 8'h97;
    localparam logic [DW-1:0] OP_LDI  = 8'h86;
    localparam logic [DW-1:0] OP_ADDI = 8'h8B;
    localparam logic [DW-1:0] OP_LDD  = 8'h96;
    localparam logic [DW-1:0] OP_LDE  = 8'hB6;
    localparam logic [DW-1:0] OP_STE  = 8'h7A;
    localparam logic [DW-1:0] OP_BRA  = 8'h20;
    localparam logic [DW-1:0] OP_PFX  = 8'h18;
    localparam logic [DW-1:0] OP_HALT = 8'h3F;
    localparam logic [DW-1:0] OP2_ABA = 8'h06;
    localparam logic [DW-1:0] OP2_LBQ = 8'h27;

    typedef enum logic [2:0] {
        ST_FETCH, ST_OPCODE, ST_BYTE1, ST_BYTE2,
        ST_BYTE3, ST_MEMACC, ST_LOADWAIT, ST_HALT
    } state_t;

    typedef enum logic [2:0] {
        IN_LDA_IMM, IN_ADD_IMM, IN_LDA_DIR, IN_LDA_EXT,
        IN_STA_EXT, IN_BRA, IN_PFX, IN_LBEQ
    } inst_t;

    typedef enum logic [2:0] {
        ALU_PASS, ALU_ADD, ALU_NEG, ALU_CLR, ALU_ASR, ALU_TST
    } alu_op_t;
endpackage

// File: rtl/accseq_alu.sv
module accseq_alu
    import accseq_pkg::*;
(
    input  alu_op_t        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [FW-1:0]  f_in,
    output logic [DW-1:0]  res,
    output logic [FW-1:0]  f_out
);
    logic [DW:0] sum;
    logic        v, c;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        res = b;
        v   = 1'b0;
        c   = f_in[FL_C];
        unique case (op)
            ALU_PASS: begin
                res = b;
            end
            ALU_ADD: begin
                res = sum[DW-1:0];
                c   = sum[DW];
                v   = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
            end
            ALU_NEG: begin
                res = DW'(0) - a;
                v   = (a == {1'b1, {(DW-1){1'b0}}});
                c   = (a != '0);
            end
            ALU_CLR: begin
                res = '0;
                c   = 1'b0;
            end
            ALU_ASR: begin
                res = {a[DW-1], a[DW-1:1]};
                c   = a[0];
                v   = a[DW-1] ^ a[0];
            end
            ALU_TST: begin
                res = a;
                c   = 1'b0;
            end
            default: res = b;
        endcase
        f_out        = '0;
        f_out[FL_N]  = res[DW-1];
        f_out[FL_Z]  = (res == '0);
        f_out[FL_V]  = v;
        f_out[FL_C]  = c;
    end
endmodule

// File: rtl/accseq_target.sv
module accseq_target
    import accseq_pkg::*;
(
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] ofs_lo,
    input  logic [DW-1:0] ofs_hi,
    input  logic          long_sel,
    output logic [AW-1:0] target
);
    logic [AW-1:0] ofs;

    always_comb begin
        if (long_sel) ofs = {ofs_hi, ofs_lo};
        else          ofs = {{(AW-DW){ofs_lo[DW-1]}}, ofs_lo};
        target = base + ofs;
    end
endmodule

// File: rtl/accseq.sv
module accseq
    import accseq_pkg::*;
#(
    parameter logic [15:0] START_PC = 16'h0800,
    parameter logic [7:0]  B_RESET  = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        done,
    output logic [15:0] out_pc,
    output logic [7:0]  out_a,
    output logic [3:0]  out_ccr
);
    state_t        state, state_n;
    inst_t         inst, inst_n;
    logic [AW-1:0] pc, pc_n, ea, ea_n, tgt;
    logic [DW-1:0] acc_a, acc_a_n, acc_b, hi, hi_n, alu_b, alu_res;
    logic [FW-1:0] ccr, ccr_n, alu_f;
    alu_op_t       alu_op;
    logic          alu_en;

    accseq_alu u_alu (
        .op(alu_op), .a(acc_a), .b(alu_b), .f_in(ccr),
        .res(alu_res), .f_out(alu_f)
    );

    accseq_target u_tgt (
        .base(pc), .ofs_lo(mem_rdata), .ofs_hi(hi),
        .long_sel(state == ST_BYTE3), .target(tgt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= START_PC;
            acc_a <= '0;
            acc_b <= B_RESET;
            ccr   <= '0;
            inst  <= IN_LDA_IMM;
            hi    <= '0;
            ea    <= '0;
        end else begin
            pc    <= pc_n;
            acc_a <= alu_en ? alu_res : acc_a_n;
            acc_b <= acc_b;
            ccr   <= alu_en ? alu_f : ccr_n;
            inst  <= inst_n;
            hi    <= hi_n;
            ea    <= ea_n;
        end
    end

    always_comb begin
        state_n  = state;
        pc_n     = pc;
        acc_a_n  = acc_a;
        ccr_n    = ccr;
        inst_n   = inst;
        hi_n     = hi;
        ea_n     = ea;
        mem_addr = pc;
        mem_we   = 1'b0;
        alu_op   = ALU_PASS;
        alu_b    = mem_rdata;
        alu_en   = 1'b0;
        unique case (state)
            ST_FETCH: begin
                pc_n    = pc + AW'(1);
                state_n = ST_OPCODE;
            end
            ST_OPCODE: begin
                state_n = ST_BYTE1;
                pc_n    = pc + AW'(1);
                case (mem_rdata)
                    OP_NEG:  begin alu_op = ALU_NEG; alu_en = 1'b1; end
                    OP_CLR:  begin alu_op = ALU_CLR; alu_en = 1'b1; end
                    OP_ASR:  begin alu_op = ALU_ASR; alu_en = 1'b1; end
                    OP_TST:  begin alu_op = ALU_TST; alu_en = 1'b1; end
                    OP_LDI:  inst_n = IN_LDA_IMM;
                    OP_ADDI: inst_n = IN_ADD_IMM;
                    OP_LDD:  inst_n = IN_LDA_DIR;
                    OP_LDE:  inst_n = IN_LDA_EXT;
                    OP_STE:  inst_n = IN_STA_EXT;
                    OP_BRA:  inst_n = IN_BRA;
                    OP_PFX:  inst_n = IN_PFX;
                    default: state_n = ST_HALT;
                endcase
                if (alu_en) state_n = ST_FETCH;
                if (alu_en || state_n == ST_HALT) pc_n = pc;
            end
            ST_BYTE1: begin
                state_n = ST_FETCH;
                case (inst)
                    IN_LDA_IMM: alu_en = 1'b1;
                    IN_ADD_IMM: begin alu_op = ALU_ADD; alu_en = 1'b1; end
                    IN_LDA_DIR: begin
                        ea_n    = {{(AW-DW){1'b0}}, mem_rdata};
                        state_n = ST_MEMACC;
                    end
                    IN_LDA_EXT, IN_STA_EXT: begin
                        hi_n    = mem_rdata;
                        pc_n    = pc + AW'(1);
                        state_n = ST_BYTE2;
                    end
                    IN_BRA: pc_n = tgt;
                    IN_PFX: begin
                        if (mem_rdata == OP2_ABA) begin
                            alu_op = ALU_ADD;
                            alu_b  = acc_b;
                            alu_en = 1'b1;
                        end else if (mem_rdata == OP2_LBQ) begin
                            inst_n  = IN_LBEQ;
                            pc_n    = pc + AW'(1);
                            state_n = ST_BYTE2;
                        end else begin
                            state_n = ST_HALT;
                        end
                    end
                    default: state_n = ST_HALT;
                endcase
            end
            ST_BYTE2: begin
                case (inst)
                    IN_LDA_EXT, IN_STA_EXT: begin
                        ea_n    = {hi, mem_rdata};
                        state_n = ST_MEMACC;
                    end
                    IN_LBEQ: begin
                        hi_n    = mem_rdata;
                        pc_n    = pc + AW'(1);
                        state_n = ST_BYTE3;
                    end
                    default: state_n = ST_HALT;
                endcase
            end
            ST_BYTE3: begin
                if (ccr[FL_Z]) pc_n = tgt;
                state_n = ST_FETCH;
            end
            ST_MEMACC: begin
                mem_addr = ea;
                if (inst == IN_STA_EXT) begin
                    mem_we  = 1'b1;
                    alu_b   = acc_a;
                    alu_en  = 1'b1;
                    state_n = ST_FETCH;
                end else begin
                    state_n = ST_LOADWAIT;
                end
            end
            ST_LOADWAIT: begin
                alu_en  = 1'b1;
                state_n = ST_FETCH;
            end
            ST_HALT: state_n = ST_HALT;
            default: state_n = ST_HALT;
        endcase
    end

    assign mem_wdata = acc_a;
    assign done      = (state == ST_HALT);
    assign out_pc    = pc;
    assign out_a     = acc_a;
    assign out_ccr   = ccr;
endmodule

// File: rtl/accseq_checker.sv
module accseq_checker #(
    parameter logic [15:0] START_PC = 16'h0800
) (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        mem_we,
    input logic [15:0] out_pc
);
    logic seen_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n && seen_rst === 1'b1) begin
            p_reset_state_r1: assert (out_pc == START_PC && !done && !mem_we)
                else $error("reset state wrong");
        end
    end

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_halt_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    p_halt_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(out_pc));

    p_store_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
endmodule

bind accseq accseq_checker #(.START_PC(START_PC)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .mem_we(mem_we), .out_pc(out_pc)
);

// File: tb/accseq_bench.sv
module accseq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        done;
    logic [15:0] out_pc;
    logic [7:0]  out_a;
    logic [3:0]  out_ccr;
    logic [7:0]  mem [0:4095];
    int          checks = 0;
    int          failures = 0;
    int          writes = 0;

    always #10 clk = ~clk;

    accseq #(.START_PC(16'h0800), .B_RESET(8'h52)) u_accseq (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done),
        .out_pc(out_pc), .out_a(out_a), .out_ccr(out_ccr)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            writes <= writes + 1;
        end
        mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [7:0] v);
        mem[addr[11:0]] = v;
    endtask

    task automatic boot();
        rst_n = 1'b0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (2) @(negedge clk);
        writes = 0;
    endtask

    task automatic run();
        int n = 0;
        rst_n = 1'b1;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            failures++;
            $display("FAIL run timeout actual=%0d expected=halt", n);
        end
    endtask

    task automatic t_reset();
        boot();
        check("R1 pc", out_pc, 16'h0800);
        check("R1 a", out_a, 0);
        check("R1 ccr", out_ccr, 0);
        check("R1 done", done, 0);
        check("R1 we", mem_we, 0);
    endtask

    task automatic t_example();
        int n = 0;
        int seen = 0;
        boot();
        put(16'h0800, 8'hB6); put(16'h0801, 8'h09); put(16'h0802, 8'h13);
        put(16'h0803, 8'h40);
        put(16'h0804, 8'h7A); put(16'h0805, 8'h09); put(16'h0806, 8'h14);
        put(16'h0807, 8'h3F);
        put(16'h0913, 8'h6C);
        rst_n = 1'b1;
        while (!done && n < 500) begin
            @(negedge clk);
            if (mem_addr == 16'h0807) seen = 1;
            n++;
        end
        check("R2 stored", mem[12'h914], 8'h94);
        check("R2 fetch 0807", seen, 1);
        check("R10 halt pc", out_pc, 16'h0808);
        check("R12 store flags C kept", out_ccr, 4'b1001);
        check("R13 one write", writes, 1);
        check("R2 neighbour", mem[12'h915], 0);
        repeat (5) @(negedge clk);
        check("R10 done held", done, 1);
        check("R10 pc held", out_pc, 16'h0808);
        check("R10 no more writes", writes, 1);
    endtask

    task automatic add_case(input logic [7:0] x, input logic [7:0] y,
                            input logic [7:0] er, input logic [3:0] ef);
        boot();
        put(16'h0800, 8'h86); put(16'h0801, x);
        put(16'h0802, 8'h8B); put(16'h0803, y);
        put(16'h0804, 8'h3F);
        run();
        check("R3 add result", out_a, er);
        check("R3 add flags", out_ccr, ef);
    endtask

    task automatic t_add();
        add_case(8'h7A, 8'h52, 8'hCC, 4'b1010);
        add_case(8'hAC, 8'h8A, 8'h36, 4'b0011);
        add_case(8'hAC, 8'h72, 8'h1E, 4'b0001);
        add_case(8'h2A, 8'h52, 8'h7C, 4'b0000);
    endtask

    task automatic t_aba();
        boot();
        put(16'h0800, 8'h86); put(16'h0801, 8'h2A);
        put(16'h0802, 8'h18); put(16'h0803, 8'h06); put(16'h0804, 8'h3F);
        run();
        check("R7 aba result", out_a, 8'h7C);
        check("R7 aba flags", out_ccr, 4'b0000);
        check("R7 pc", out_pc, 16'h0805);
        boot();
        put(16'h0800, 8'h86); put(16'h0801, 8'hAC);
        put(16'h0802, 8'h18); put(16'h0803, 8'h06); put(16'h0804, 8'h3F);
        run();
        check("R7 aba negative", out_a, 8'hFE);
        check("R7 aba neg flags", out_ccr, 4'b1000);
    endtask

    task automatic inh_case(input string req, input logic [7:0] x, input logic [7:0] op,
                            input logic [7:0] er, input logic [3:0] ef);
        boot();
        put(16'h0800, 8'h86); put(16'h0801, x);
        put(16'h0802, op); put(16'h0803, 8'h3F);
        run();
        check(req, out_a, er);
        check(req, out_ccr, ef);
        check(req, out_pc, 16'h0804);
    endtask

    task automatic t_inherent();
        inh_case("R5 neg 80", 8'h80, 8'h40, 8'h80, 4'b1011);
        inh_case("R5 neg 00", 8'h00, 8'h40, 8'h00, 4'b0100);
        inh_case("R5 neg 01", 8'h01, 8'h40, 8'hFF, 4'b1001);
        inh_case("R6 asr", 8'h81, 8'h47, 8'hC0, 4'b1001);
        inh_case("R6 asr pos", 8'h03, 8'h47, 8'h01, 4'b0011);
        inh_case("R6 clr", 8'h55, 8'h87, 8'h00, 4'b0100);
        inh_case("R6 tst", 8'h80, 8'h97, 8'h80, 4'b1000);
    endtask

    task automatic t_direct();
        boot();
        put(16'h0800, 8'h96); put(16'h0801, 8'h50); put(16'h0802, 8'h3F);
        put(16'h0050, 8'h9C);
        run();
        check("R4 direct load", out_a, 8'h9C);
        check("R12 load flags", out_ccr, 4'b1000);
        boot();
        put(16'h0800, 8'h86); put(16'h0801, 8'h05);
        put(16'h0802, 8'h40);
        put(16'h0803, 8'hB6); put(16'h0804, 8'h09); put(16'h0805, 8'h00);
        put(16'h0806, 8'h3F);
        run();
        check("R12 ext load zero keeps C", out_ccr, 4'b0101);
        check("R2 ext load", out_a, 8'h00);
    endtask

    task automatic t_branch();
        boot();
        put(16'h0800, 8'h20); put(16'h0801, 8'h04);
        put(16'h0802, 8'h86); put(16'h0803, 8'h11); put(16'h0804, 8'h3F);
        put(16'h0806, 8'h86); put(16'h0807, 8'h22); put(16'h0808, 8'h3F);
        run();
        check("R8 forward a", out_a, 8'h22);
        check("R8 forward pc", out_pc, 16'h0809);
        boot();
        put(16'h0800, 8'h20); put(16'h0801, 8'h0E);
        put(16'h0802, 8'h3F);
        put(16'h0810, 8'h86); put(16'h0811, 8'h44);
        put(16'h0812, 8'h20); put(16'h0813, 8'hEE);
        run();
        check("R8 backward a", out_a, 8'h44);
        check("R8 backward pc", out_pc, 16'h0803);
    endtask

    task automatic t_lbeq();
        boot();
        put(16'h0800, 8'h87);
        put(16'h0801, 8'h18); put(16'h0802, 8'h27);
        put(16'h0803, 8'h00); put(16'h0804, 8'h10);
        put(16'h0805, 8'h86); put(16'h0806, 8'h01); put(16'h0807, 8'h3F);
        put(16'h0815, 8'h86); put(16'h0816, 8'h02); put(16'h0817, 8'h3F);
        run();
        check("R9 taken a", out_a, 8'h02);
        check("R9 taken pc", out_pc, 16'h0818);
        boot();
        put(16'h0800, 8'h86); put(16'h0801, 8'h05);
        put(16'h0802, 8'h18); put(16'h0803, 8'h27);
        put(16'h0804, 8'h00); put(16'h0805, 8'h10);
        put(16'h0806, 8'h86); put(16'h0807, 8'h07); put(16'h0808, 8'h3F);
        put(16'h0816, 8'h86); put(16'h0817, 8'h09); put(16'h0818, 8'h3F);
        run();
        check("R9 not taken a", out_a, 8'h07);
        check("R9 not taken pc", out_pc, 16'h0809);
    endtask

    task automatic t_unknown();
        boot();
        put(16'h0800, 8'h86); put(16'h0801, 8'h5A);
        put(16'h0802, 8'h01);
        put(16'h0803, 8'h86); put(16'h0804, 8'hFF); put(16'h0805, 8'h3F);
        run();
        check("R11 unknown a", out_a, 8'h5A);
        check("R11 unknown pc", out_pc, 16'h0803);
        boot();
        put(16'h0800, 8'h86); put(16'h0801, 8'h33);
        put(16'h0802, 8'h18); put(16'h0803, 8'h99);
        put(16'h0804, 8'h86); put(16'h0805, 8'hFF); put(16'h0806, 8'h3F);
        run();
        check("R11 bad prefix a", out_a, 8'h33);
        check("R11 bad prefix pc", out_pc, 16'h0804);
        check("R11 no write", writes, 0);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_add();
        t_aba();
        t_inherent();
        t_direct();
        t_branch();
        t_lbeq();
        t_unknown();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule